// File: doc/BRIEF.md
# External Trigger Edge Counter

This block lets a timer count edges of an external trigger rather than ticks of the peripheral clock. A two-bit selector routes one of four trigger sources into the path: a peripheral-clock-derived line, a slow internal oscillator line, an optional 32 kHz line, or an external clock pin. The pin source can be ANDed with a mask pin to form a gated clock. All four sources are treated as asynchronous data inputs.

The selected trigger is brought into the peripheral clock domain by a multi-flop synchronizer. It then passes a programmable stability filter and an edge detector with selectable polarity. An edge prescaler divides the qualifying edges by 1, 2, 4 or 8. Each prescaler wrap advances an up-counter by one and raises a one-cycle count pulse. Counting happens only while both the external-clock mode bit and the counter-enable bit are set. Every trigger source must toggle slower than half the peripheral clock rate.

Top module: `ext_trig_counter`

## Requirements
- R1: After reset, `count` is 0 and `count_pulse` is 0.
- R2: `src_sel` routes the trigger: 2'b00 takes `src_pclk`, 2'b01 `src_lfrc`, 2'b10 `src_32k`, 2'b11 `src_pin`. Edges on an unselected source do not change `count`.
- R3: With `src_sel`=2'b11 and `gate_en`=1, the trigger is `src_pin` AND `mask_pin`, so a low mask blocks all counts. With `gate_en`=0, `mask_pin` has no effect.
- R4: `trig_inv`=0 counts rising trigger edges; `trig_inv`=1 counts falling trigger edges.
- R5: `presc_sel` 2'b00, 2'b01, 2'b10 and 2'b11 make `count` advance once per 1, 2, 4 and 8 qualifying edges respectively.
- R6: With `filt_len`=N, a new synchronized level is accepted only after N+1 consecutive clock samples at that level. N=0 means no filtering. A trigger level held for fewer than N+1 clocks is dropped.
- R7: With prescale 1 and `filt_len`=N, an input edge that is applied just before clock edge 1 increments `count` at clock edge 4+N, never earlier.
- R8: While `ext_mode_en` or `cnt_en` is 0, `count` is frozen and the prescaler's edge counter is held at zero. Edges seen before disabling are therefore discarded on re-enable.
- R9: `count` is CNT_W bits wide (16 by default) and wraps from all ones to zero.
- R10: `count_pulse` is high for exactly one clock each time `count` increments. `count` changes in no other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Trigger source select |
| gate_en | input | 1 | Gate the pin source with the mask pin |
| src_pclk | input | 1 | Source 0 trigger line |
| src_lfrc | input | 1 | Source 1, slow internal oscillator |
| src_32k | input | 1 | Source 2, optional 32 kHz clock |
| src_pin | input | 1 | Source 3, external clock pin |
| mask_pin | input | 1 | Mask for the pin source |
| trig_inv | input | 1 | 0 = rising edges, 1 = falling edges |
| presc_sel | input | 2 | Edge prescale code |
| filt_len | input | 4 | Filter stability length N |
| ext_mode_en | input | 1 | External clock mode enable |
| cnt_en | input | 1 | Counter enable |
| count | output | CNT_W | Counter value |
| count_pulse | output | 1 | One-clock pulse on each increment |

## Verification
A stuck synchronizer or filter stage shows at the ports as a missing or late increment. This is visible four plus N clocks after the stimulus edge. A prescaler that fails to clear or wrap shows as a count that differs from the edge count divided by the ratio once a burst has drained. A filter with the wrong run length either accepts an N-cycle pulse or rejects an N+1-cycle pulse, and the count shows this within a few clocks. A counter or pulse register that drifts breaks the agreement between the number of `count_pulse` cycles and the change in `count`.

// File: rtl/etc_pkg.sv
package etc_pkg;

  typedef enum logic [1:0] {
    SRC_PCLK = 2'b00,
    SRC_LFRC = 2'b01,
    SRC_32K  = 2'b10,
    SRC_PIN  = 2'b11
  } src_e;

  // number of qualifying edges per counter increment
  function automatic int unsigned psc_ratio(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

  // filter accepts a new level once the run of differing samples reaches len
  function automatic logic filt_accept(input logic [3:0] run, input logic [3:0] len);
    return run >= len;
  endfunction

  // next counter value with natural wrap
  function automatic logic [31:0] cnt_next(input logic [31:0] cur);
    return cur + 32'd1;
  endfunction

endpackage

// File: rtl/etc_src_select.sv
module etc_src_select
  import etc_pkg::*;
(
  input  logic [1:0] src_sel,
  input  logic       gate_en,
  input  logic       src_pclk,
  input  logic       src_lfrc,
  input  logic       src_32k,
  input  logic       src_pin,
  input  logic       mask_pin,
  output logic       trig_raw
);

  logic pin_gated;

  assign pin_gated = src_pin & (mask_pin | ~gate_en);

  always_comb begin
    unique case (src_e'(src_sel))
      SRC_PCLK: trig_raw = src_pclk;
      SRC_LFRC: trig_raw = src_lfrc;
      SRC_32K:  trig_raw = src_32k;
      default:  trig_raw = pin_gated;
    endcase
  end

endmodule

// File: rtl/etc_sync_filter.sv
module etc_sync_filter
  import etc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_raw,
  input  logic [FILT_W-1:0] filt_len,
  output logic              sync_lvl,
  output logic              filt_lvl
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_W-1:0]      run_q;
  logic                   filt_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= trig_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (sync_lvl == filt_q) begin
      run_q  <= '0;
    end else if (filt_accept(4'(run_q), 4'(filt_len))) begin
      filt_q <= sync_lvl;
      run_q  <= '0;
    end else begin
      run_q  <= run_q + 1'b1;
    end
  end

  assign filt_lvl = filt_q;

endmodule

// File: rtl/etc_edge_prescale.sv
module etc_edge_prescale
  import etc_pkg::*;
#(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             filt_lvl,
  input  logic             trig_inv,
  input  logic [PSC_W-1:0] presc_sel,
  input  logic             active,
  output logic             edge_evt,
  output logic             tick
);

  localparam int PCW = (1 << PSC_W) - 1;

  logic           lvl_d;
  logic           rise, fall;
  logic [PCW-1:0] psc_q;
  logic [PCW-1:0] psc_last;
  logic           wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= filt_lvl;
  end

  assign rise     = filt_lvl & ~lvl_d;
  assign fall     = ~filt_lvl & lvl_d;
  assign edge_evt = trig_inv ? fall : rise;

  assign psc_last = PCW'(psc_ratio(2'(presc_sel)) - 1);
  assign wrap     = (psc_q >= psc_last);
  assign tick     = active & edge_evt & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        psc_q <= '0;
    else if (!active)  psc_q <= '0;
    else if (edge_evt) psc_q <= wrap ? '0 : psc_q + 1'b1;
  end

endmodule

// File: rtl/ext_trig_counter.sv
module ext_trig_counter
  import etc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 4,
  parameter int PSC_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_sel,
  input  logic              gate_en,
  input  logic              src_pclk,
  input  logic              src_lfrc,
  input  logic              src_32k,
  input  logic              src_pin,
  input  logic              mask_pin,
  input  logic              trig_inv,
  input  logic [PSC_W-1:0]  presc_sel,
  input  logic [FILT_W-1:0] filt_len,
  input  logic              ext_mode_en,
  input  logic              cnt_en,
  output logic [CNT_W-1:0]  count,
  output logic              count_pulse
);

  logic trig_raw;
  logic sync_lvl;
  logic filt_lvl;
  logic edge_evt;
  logic tick;
  logic active;

  assign active = ext_mode_en & cnt_en;

  etc_src_select u_sel (
    .src_sel  (src_sel),
    .gate_en  (gate_en),
    .src_pclk (src_pclk),
    .src_lfrc (src_lfrc),
    .src_32k  (src_32k),
    .src_pin  (src_pin),
    .mask_pin (mask_pin),
    .trig_raw (trig_raw)
  );

  etc_sync_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_W      (FILT_W)
  ) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_raw (trig_raw),
    .filt_len (filt_len),
    .sync_lvl (sync_lvl),
    .filt_lvl (filt_lvl)
  );

  etc_edge_prescale #(
    .PSC_W (PSC_W)
  ) u_psc (
    .clk       (clk),
    .rst_n     (rst_n),
    .filt_lvl  (filt_lvl),
    .trig_inv  (trig_inv),
    .presc_sel (presc_sel),
    .active    (active),
    .edge_evt  (edge_evt),
    .tick      (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count       <= '0;
      count_pulse <= 1'b0;
    end else begin
      count_pulse <= tick;
      if (tick) count <= CNT_W'(cnt_next(32'(count)));
    end
  end

endmodule

// File: rtl/ext_trig_counter_chk.sv
module ext_trig_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_mode_en,
  input logic             cnt_en,
  input logic [CNT_W-1:0] count,
  input logic             count_pulse,
  input logic             sync_lvl,
  input logic             filt_lvl,
  input logic             edge_evt
);

  // R10 and R9: each pulse accompanies a single increment that wraps modulo 2^CNT_W
  a_r10_pulse_increments: assert property (@(posedge clk) disable iff (!rst_n)
    count_pulse |-> count == CNT_W'($past(count) + 1'b1));

  // R10: count holds whenever no pulse is flagged
  a_r10_hold_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !count_pulse |-> count == $past(count));

  // R8: a disabled counter produces no pulse in the next cycle
  a_r8_inactive_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_mode_en && cnt_en) |=> !count_pulse);

  // R6: the filtered level only ever moves to the synchronized level
  a_r6_filter_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |-> filt_lvl == $past(sync_lvl));

  // R7: a pulse is always preceded by a detected trigger edge
  a_r7_pulse_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    count_pulse |-> $past(edge_evt));

endmodule

bind ext_trig_counter ext_trig_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_mode_en (ext_mode_en),
  .cnt_en      (cnt_en),
  .count       (count),
  .count_pulse (count_pulse),
  .sync_lvl    (sync_lvl),
  .filt_lvl    (filt_lvl),
  .edge_evt    (edge_evt)
);

// File: tb/ext_trig_counter_tb.sv
module ext_trig_counter_tb;

  localparam int CW = 10;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] drv;
    logic       gate;
    logic       mask;
    logic       inv;
    logic [1:0] psc;
    logic [7:0] edges;
  } vec_t;

  localparam vec_t VECS [0:11] = '{
    '{sel:2'd0, drv:2'd0, gate:1'b0, mask:1'b0, inv:1'b0, psc:2'd0, edges:8'd5},
    '{sel:2'd1, drv:2'd1, gate:1'b0, mask:1'b0, inv:1'b0, psc:2'd0, edges:8'd6},
    '{sel:2'd2, drv:2'd2, gate:1'b0, mask:1'b0, inv:1'b0, psc:2'd1, edges:8'd6},
    '{sel:2'd3, drv:2'd3, gate:1'b0, mask:1'b0, inv:1'b0, psc:2'd2, edges:8'd8},
    '{sel:2'd3, drv:2'd3, gate:1'b1, mask:1'b0, inv:1'b0, psc:2'd0, edges:8'd5},
    '{sel:2'd3, drv:2'd3, gate:1'b1, mask:1'b1, inv:1'b0, psc:2'd0, edges:8'd5},
    '{sel:2'd1, drv:2'd2, gate:1'b0, mask:1'b0, inv:1'b0, psc:2'd0, edges:8'd4},
    '{sel:2'd0, drv:2'd3, gate:1'b0, mask:1'b0, inv:1'b0, psc:2'd0, edges:8'd4},
    '{sel:2'd2, drv:2'd2, gate:1'b0, mask:1'b0, inv:1'b1, psc:2'd3, edges:8'd16},
    '{sel:2'd0, drv:2'd0, gate:1'b0, mask:1'b0, inv:1'b0, psc:2'd3, edges:8'd7},
    '{sel:2'd1, drv:2'd1, gate:1'b0, mask:1'b0, inv:1'b1, psc:2'd1, edges:8'd5},
    '{sel:2'd3, drv:2'd3, gate:1'b0, mask:1'b1, inv:1'b0, psc:2'd3, edges:8'd9}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    src_sel = 2'd0;
  logic          gate_en = 1'b0;
  logic          src_pclk = 1'b0, src_lfrc = 1'b0, src_32k = 1'b0, src_pin = 1'b0;
  logic          mask_pin = 1'b0;
  logic          trig_inv = 1'b0;
  logic [1:0]    presc_sel = 2'd0;
  logic [3:0]    filt_len = 4'd0;
  logic          ext_mode_en = 1'b0;
  logic          cnt_en = 1'b0;
  logic [CW-1:0] count;
  logic          count_pulse;

  int checks = 0;
  int errors = 0;
  int pulse_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_trig_counter #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .gate_en(gate_en),
    .src_pclk(src_pclk), .src_lfrc(src_lfrc), .src_32k(src_32k), .src_pin(src_pin),
    .mask_pin(mask_pin), .trig_inv(trig_inv), .presc_sel(presc_sel), .filt_len(filt_len),
    .ext_mode_en(ext_mode_en), .cnt_en(cnt_en), .count(count), .count_pulse(count_pulse)
  );

  always @(negedge clk) if (count_pulse) pulse_seen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_src(input logic [1:0] idx, input logic val);
    case (idx)
      2'd0: src_pclk = val;
      2'd1: src_lfrc = val;
      2'd2: src_32k  = val;
      default: src_pin = val;
    endcase
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [1:0] idx, input int hi, input int lo);
    set_src(idx, 1'b1);
    waitn(hi);
    set_src(idx, 1'b0);
    waitn(lo);
  endtask

  task automatic restart_psc();
    cnt_en = 1'b0;
    waitn(1);
    cnt_en = 1'b1;
    waitn(1);
  endtask

  function automatic int expect_cnt(input vec_t v);
    if (v.drv != v.sel) return 0;
    if (v.sel == 2'd3 && v.gate && !v.mask) return 0;
    return int'(v.edges) / (1 << v.psc);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base, pbase;
    waitn(3);
    chk("R1 count after reset", int'(count), 0);
    chk("R1 pulse after reset", int'(count_pulse), 0);
    rst_n = 1'b1;
    ext_mode_en = 1'b1;
    cnt_en = 1'b1;
    waitn(2);

    // table walk: R2 R3 R4 R5
    foreach (VECS[k]) begin
      src_sel   = VECS[k].sel;
      gate_en   = VECS[k].gate;
      mask_pin  = VECS[k].mask;
      trig_inv  = VECS[k].inv;
      presc_sel = VECS[k].psc;
      waitn(2);
      restart_psc();
      base  = int'(count);
      pbase = pulse_seen;
      for (int e = 0; e < int'(VECS[k].edges); e++) pulse(VECS[k].drv, 3, 3);
      waitn(8);
      chk($sformatf("R2/R3/R5 row %0d count delta", k), (int'(count) - base) & ((1 << CW) - 1), expect_cnt(VECS[k]));
      chk($sformatf("R10 row %0d pulse count", k), pulse_seen - pbase, expect_cnt(VECS[k]));
    end

    // R7 latency, filter 0
    src_sel = 2'd1; gate_en = 1'b0; mask_pin = 1'b0; trig_inv = 1'b0; presc_sel = 2'd0; filt_len = 4'd0;
    restart_psc();
    base = int'(count);
    src_lfrc = 1'b1;
    waitn(3);
    chk("R7 no count before clock 4", int'(count), base);
    chk("R7 no pulse before clock 4", int'(count_pulse), 0);
    waitn(1);
    chk("R7 count at clock 4", int'(count), (base + 1) & ((1 << CW) - 1));
    chk("R10 pulse at clock 4", int'(count_pulse), 1);
    waitn(1);
    chk("R10 pulse lasts one clock", int'(count_pulse), 0);
    src_lfrc = 1'b0;
    waitn(8);

    // R7 latency with filter 3
    filt_len = 4'd3;
    waitn(2);
    base = int'(count);
    src_lfrc = 1'b1;
    waitn(6);
    chk("R7 filtered no count before clock 7", int'(count), base);
    waitn(1);
    chk("R7 filtered count at clock 7", int'(count), (base + 1) & ((1 << CW) - 1));
    src_lfrc = 1'b0;
    waitn(12);

    // R6 boundary: 3-clock pulse dropped, 4-clock pulse kept
    base = int'(count);
    pulse(2'd1, 3, 12);
    chk("R6 short pulse ignored", int'(count), base);
    pulse(2'd1, 4, 12);
    chk("R6 N+1 pulse accepted", int'(count), (base + 1) & ((1 << CW) - 1));
    filt_len = 4'd0;
    waitn(4);

    // R4 falling polarity
    trig_inv = 1'b1;
    waitn(2);
    base = int'(count);
    src_lfrc = 1'b1;
    waitn(8);
    chk("R4 rising edge ignored when inverted", int'(count), base);
    src_lfrc = 1'b0;
    waitn(8);
    chk("R4 falling edge counted when inverted", int'(count), (base + 1) & ((1 << CW) - 1));
    trig_inv = 1'b0;
    waitn(2);

    // R8 disables
    base = int'(count);
    ext_mode_en = 1'b0;
    pulse(2'd1, 3, 8);
    chk("R8 mode off freezes count", int'(count), base);
    ext_mode_en = 1'b1;
    cnt_en = 1'b0;
    pulse(2'd1, 3, 8);
    chk("R8 counter off freezes count", int'(count), base);
    cnt_en = 1'b1;
    presc_sel = 2'd1;
    waitn(2);
    pulse(2'd1, 3, 8);
    chk("R8 first of two edges no count", int'(count), base);
    restart_psc();
    pulse(2'd1, 3, 8);
    chk("R8 prescaler cleared on disable", int'(count), base);
    pulse(2'd1, 3, 8);
    chk("R8 count after two fresh edges", int'(count), (base + 1) & ((1 << CW) - 1));
    presc_sel = 2'd0;
    waitn(2);

    // R9 wrap
    begin
      int remaining;
      remaining = ((1 << CW) - 1) - int'(count);
      for (int e = 0; e < remaining; e++) pulse(2'd1, 2, 2);
      waitn(8);
      chk("R9 count at all ones", int'(count), (1 << CW) - 1);
      pulse(2'd1, 2, 8);
      chk("R9 wrap to zero", int'(count), 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule